// File: doc/BRIEF.md
# Hyperbolic Range-Extension Combiner

This block rebuilds the hyperbolic sine and cosine of a large argument from the results for a small one. Upstream logic splits the argument as x = q·ln2 + r, with q an integer and r in [0, ln2). A core that only accepts arguments in [-1, 1) then supplies sinh(r) and cosh(r). The combiner takes q and that pair and returns sinh(x) and cosh(x). It needs no multiplier for this.

The sum cosh(r) + sinh(r) equals e^r, and the difference cosh(r) − sinh(r) equals e^-r. The block scales the first by 2^(q-1) and the second by 2^(-q-1), using shifts whose direction follows the sign of the shift amount. Subtracting the two scaled terms gives sinh(x), and adding them gives cosh(x). Each result is clamped to the signed output range.

The pipeline has two register stages and accepts one argument every cycle. Each result carries a valid flag, and the output holds its last result while no valid result is leaving.

Top module: `hrx_combiner`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly two clock cycles, and one argument can be accepted on every cycle.
- R2: When a result is valid, `sinh_out` equals sat(T_a − T_b). Here E = ch_in + sh_in, F = ch_in − sh_in, T_a = E scaled by 2^(q-1) and T_b = F scaled by 2^(-q-1), all as integers in units of 2^-FRAC.
- R3: When a result is valid, `cosh_out` equals sat(T_a + T_b), using the same terms as R2.
- R4: `q_in` is a two's complement integer. A non-negative scale exponent shifts left and a negative one shifts right, so a negative q reverses the shift direction of both terms.
- R5: A right shift drops the bits shifted out of each term before the two terms are combined. This rounds each term toward minus infinity. For example, q = 0, sh = 1 LSB, ch = 0 gives sinh = +1 LSB and cosh = −1 LSB.
- R6: A result outside the signed OUT_INT+FRAC bit range is clamped to the largest or smallest code of that width and never wraps.
- R7: While `rst` is high at a clock edge, `out_valid` goes low and both data outputs go to zero on that edge.
- R8: While `out_valid` is low, `sinh_out` and `cosh_out` keep the last valid result, or zero after reset.
- R9: The fixed-point formats are as follows. `sh_in` is signed with FRAC fraction bits and 2 integer bits. `ch_in` is unsigned with FRAC fraction bits and 1 integer bit. Both outputs are signed with FRAC fraction bits. For example, with FRAC = 8, q = 1, ch = 256 and sh = 0 give sinh = 192 (0.75) and cosh = 320 (1.25).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The argument presented on this cycle is valid |
| q_in | input | QW | Signed integer multiple of ln2 |
| sh_in | input | FRAC+2 | sinh of the reduced argument, signed |
| ch_in | input | FRAC+1 | cosh of the reduced argument, unsigned |
| out_valid | output | 1 | The results on this cycle are valid |
| sinh_out | output | OUT_INT+FRAC | sinh(x), signed, saturated |
| cosh_out | output | OUT_INT+FRAC | cosh(x), signed, saturated |

## Verification
Each fault inside the block shows at the ports within two cycles of the argument that exposes it:

- **Swapped sum and difference:** the two outputs move apart by the wrong amount for the first argument with a nonzero sinh.
- **Reversed shift direction or off-by-one exponent:** the output is scaled wrongly by a power of four or two for every q of that sign.
- **Missing clamp:** a wrapped result with the wrong sign appears for large |q|.
- **Stage register loading on an invalid cycle:** an output changes while `out_valid` is low.

Because the stage has no state across arguments, sweeping q across its whole range against a dense grid of input pairs reaches every shift amount and both saturation limits.

// File: rtl/hrx_pkg.sv
package hrx_pkg;

    // Extra bit kept on the combining adder so that a sum of two shifted
    // terms never wraps before saturation.
    localparam int HRX_SUM_GUARD = 1;

    typedef enum logic {
        HRX_SHL = 1'b0,
        HRX_SHR = 1'b1
    } hrx_dir_e;

    // Width of e^r / e^-r: the sum of a (FRAC+2)-bit signed and a
    // (FRAC+1)-bit unsigned value needs FRAC+3 signed bits.
    function automatic int hrx_exp_width(input int frac);
        return frac + 3;
    endfunction

    // Largest left shift applied is 2^(QW-1)-1 (term b at the most negative q).
    function automatic int hrx_max_left(input int qw);
        return (1 << (qw - 1)) - 1;
    endfunction

endpackage

// File: rtl/hrx_front.sv
// Forms e^r and e^-r from the input pair and the two scale exponents.
module hrx_front #(
    parameter int FRAC = 8,
    parameter int QW   = 4,
    localparam int EW  = hrx_pkg::hrx_exp_width(FRAC),
    localparam int AW  = QW + 1
) (
    input  logic signed [QW-1:0]   q_val,
    input  logic signed [FRAC+1:0] sh_val,
    input  logic        [FRAC:0]   ch_val,
    output logic signed [EW-1:0]   e_pos,
    output logic signed [EW-1:0]   e_neg,
    output logic signed [AW-1:0]   amt_a,
    output logic signed [AW-1:0]   amt_b
);
    logic signed [EW-1:0] sh_ext;
    logic signed [EW-1:0] ch_ext;
    logic signed [AW-1:0] q_ext;

    always_comb begin
        sh_ext = {sh_val[FRAC+1], sh_val};
        ch_ext = {2'b00, ch_val};
        e_pos  = ch_ext + sh_ext;
        e_neg  = ch_ext - sh_ext;
        q_ext  = {q_val[QW-1], q_val};
        amt_a  = q_ext - AW'(1);
        amt_b  = -q_ext - AW'(1);
    end
endmodule

// File: rtl/hrx_pow2_shift.sv
// Scales a signed value by 2^amt with a logarithmic shifter; a negative
// amount shifts right arithmetically, dropping the bits shifted out.
module hrx_pow2_shift #(
    parameter int IN_W  = 11,
    parameter int OUT_W = 19,
    parameter int AMT_W = 5
) (
    input  logic signed [IN_W-1:0]  din,
    input  logic signed [AMT_W-1:0] amt,
    output logic signed [OUT_W-1:0] dout
);
    hrx_pkg::hrx_dir_e     dir;
    logic [AMT_W-1:0]      mag;
    logic signed [OUT_W-1:0] stg [AMT_W+1];

    always_comb begin
        dir = amt[AMT_W-1] ? hrx_pkg::HRX_SHR : hrx_pkg::HRX_SHL;
        mag = amt[AMT_W-1] ? AMT_W'(-amt) : AMT_W'(amt);
    end

    assign stg[0] = {{(OUT_W-IN_W){din[IN_W-1]}}, din};

    for (genvar i = 0; i < AMT_W; i++) begin : g_stage
        localparam int STEP = 1 << i;
        logic signed [OUT_W-1:0] moved;
        always_comb begin
            if (dir == hrx_pkg::HRX_SHR) begin
                moved = stg[i] >>> STEP;
            end else begin
                moved = stg[i] <<< STEP;
            end
        end
        assign stg[i+1] = mag[i] ? moved : stg[i];
    end

    assign dout = stg[AMT_W];
endmodule

// File: rtl/hrx_sat.sv
// Clamps a signed value to a narrower signed width.
module hrx_sat #(
    parameter int IN_W  = 20,
    parameter int OUT_W = 17
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    if (IN_W > OUT_W) begin : g_clamp
        logic [IN_W-OUT_W:0] top;
        logic                fits;
        always_comb begin
            top  = din[IN_W-1:OUT_W-1];
            fits = (top == '0) || (top == '1);
            if (fits) begin
                dout = din[OUT_W-1:0];
            end else if (din[IN_W-1]) begin
                dout = {1'b1, {(OUT_W-1){1'b0}}};
            end else begin
                dout = {1'b0, {(OUT_W-1){1'b1}}};
            end
        end
    end else begin : g_widen
        assign dout = OUT_W'(din);
    end
endmodule

// File: rtl/hrx_combiner.sv
module hrx_combiner #(
    parameter int FRAC    = 8,
    parameter int QW      = 4,
    parameter int OUT_INT = 9
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic signed [QW-1:0]            q_in,
    input  logic signed [FRAC+1:0]          sh_in,
    input  logic        [FRAC:0]            ch_in,
    output logic                            out_valid,
    output logic signed [OUT_INT+FRAC-1:0]  sinh_out,
    output logic signed [OUT_INT+FRAC-1:0]  cosh_out
);
    localparam int EW = hrx_pkg::hrx_exp_width(FRAC);
    localparam int AW = QW + 1;
    localparam int SW = EW + hrx_pkg::hrx_max_left(QW) + 1;
    localparam int W  = SW + hrx_pkg::HRX_SUM_GUARD;
    localparam int OW = OUT_INT + FRAC;

    typedef struct packed {
        logic                 vld;
        logic signed [EW-1:0] e_pos;
        logic signed [EW-1:0] e_neg;
        logic signed [AW-1:0] amt_a;
        logic signed [AW-1:0] amt_b;
    } s1_t;

    typedef struct packed {
        logic                 vld;
        logic signed [OW-1:0] sh;
        logic signed [OW-1:0] ch;
    } s2_t;

    s1_t s1_d, s1_q;
    s2_t s2_d, s2_q;

    logic signed [EW-1:0] f_pos, f_neg;
    logic signed [AW-1:0] f_amt_a, f_amt_b;
    logic signed [SW-1:0] term_a, term_b;
    logic signed [W-1:0]  diff_w, sum_w;
    logic signed [OW-1:0] sat_sh, sat_ch;

    hrx_front #(.FRAC(FRAC), .QW(QW)) u_front (
        .q_val (q_in),
        .sh_val(sh_in),
        .ch_val(ch_in),
        .e_pos (f_pos),
        .e_neg (f_neg),
        .amt_a (f_amt_a),
        .amt_b (f_amt_b)
    );

    hrx_pow2_shift #(.IN_W(EW), .OUT_W(SW), .AMT_W(AW)) u_shift_a (
        .din (s1_q.e_pos),
        .amt (s1_q.amt_a),
        .dout(term_a)
    );

    hrx_pow2_shift #(.IN_W(EW), .OUT_W(SW), .AMT_W(AW)) u_shift_b (
        .din (s1_q.e_neg),
        .amt (s1_q.amt_b),
        .dout(term_b)
    );

    always_comb begin
        diff_w = W'(term_a) - W'(term_b);
        sum_w  = W'(term_a) + W'(term_b);
    end

    hrx_sat #(.IN_W(W), .OUT_W(OW)) u_sat_sh (
        .din (diff_w),
        .dout(sat_sh)
    );

    hrx_sat #(.IN_W(W), .OUT_W(OW)) u_sat_ch (
        .din (sum_w),
        .dout(sat_ch)
    );

    always_comb begin
        s1_d     = s1_q;
        s1_d.vld = in_valid;
        if (in_valid) begin
            s1_d.e_pos = f_pos;
            s1_d.e_neg = f_neg;
            s1_d.amt_a = f_amt_a;
            s1_d.amt_b = f_amt_b;
        end

        s2_d     = s2_q;
        s2_d.vld = s1_q.vld;
        if (s1_q.vld) begin
            s2_d.sh = sat_sh;
            s2_d.ch = sat_ch;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid = s2_q.vld;
    assign sinh_out  = s2_q.sh;
    assign cosh_out  = s2_q.ch;
endmodule

// File: rtl/hrx_combiner_chk.sv
module hrx_combiner_chk #(
    parameter int OW = 17
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          out_valid,
    input logic [OW-1:0] sinh_out,
    input logic [OW-1:0] cosh_out
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R1: valid leaves exactly two cycles after it enters
    a_r1_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R7: reset clears the output stage
    a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && sinh_out == '0 && cosh_out == '0));

    // R8: outputs hold while no result leaves
    a_r8_hold_sinh: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1 && !out_valid) |-> $stable(sinh_out));

    a_r8_hold_cosh: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1 && !out_valid) |-> $stable(cosh_out));
endmodule

bind hrx_combiner hrx_combiner_chk #(.OW(OUT_INT + FRAC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .sinh_out (sinh_out),
    .cosh_out (cosh_out)
);

// File: tb/sim_hrx_combiner.sv
module sim_hrx_combiner;
    localparam int CLK_PERIOD = 10;
    localparam int FRAC    = 8;
    localparam int QW      = 4;
    localparam int OUT_INT = 9;
    localparam int OW      = OUT_INT + FRAC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [QW-1:0]   q_in = '0;
    logic signed [FRAC+1:0] sh_in = '0;
    logic        [FRAC:0]   ch_in = '0;
    logic                   out_valid;
    logic signed [OW-1:0]   sinh_out, cosh_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // two-deep model pipeline: index 0 = driven last step, 1 = two steps ago
    bit     pv [2];
    longint ps [2];
    longint pc [2];
    string  pts [2];
    string  ptc [2];
    longint held_s = 0;
    longint held_c = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hrx_combiner #(.FRAC(FRAC), .QW(QW), .OUT_INT(OUT_INT)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .q_in(q_in),
        .sh_in(sh_in), .ch_in(ch_in), .out_valid(out_valid),
        .sinh_out(sinh_out), .cosh_out(cosh_out)
    );

    // value * 2^k, rounded toward minus infinity when k < 0
    function automatic longint scale2(input longint v, input int k);
        longint d, qq;
        if (k >= 0) return v * (longint'(1) << k);
        d  = longint'(1) << (-k);
        qq = v / d;
        if ((v % d) != 0 && v < 0) qq = qq - 1;
        return qq;
    endfunction

    function automatic longint clampw(input longint v);
        longint hi, lo;
        hi = (longint'(1) << (OW - 1)) - 1;
        lo = -(longint'(1) << (OW - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic bit clipped(input longint v);
        return clampw(v) != v;
    endfunction

    task automatic check_outputs();
        longint es, ec;
        checks++;
        if (out_valid !== pv[1]) begin
            fails++;
            $display("FAIL R1 out_valid: actual %0b expected %0b", out_valid, pv[1]);
        end
        if (pv[1]) begin
            es = ps[1]; ec = pc[1];
        end else begin
            es = held_s; ec = held_c;
        end
        if (longint'(sinh_out) != es) begin
            fails++;
            $display("FAIL %s sinh_out: actual %0d expected %0d",
                     pv[1] ? pts[1] : "R8", sinh_out, es);
        end
        if (longint'(cosh_out) != ec) begin
            fails++;
            $display("FAIL %s cosh_out: actual %0d expected %0d",
                     pv[1] ? ptc[1] : "R8", cosh_out, ec);
        end
        if (pv[1]) begin
            held_s = es; held_c = ec;
        end
    endtask

    task automatic step(input bit v, input int q, input int sh, input int ch,
                        input string tag);
        longint e, f, ta, tb, rs, rc;
        @(negedge clk);
        check_outputs();
        e  = longint'(ch) + longint'(sh);
        f  = longint'(ch) - longint'(sh);
        ta = scale2(e, q - 1);
        tb = scale2(f, -q - 1);
        rs = ta - tb;
        rc = ta + tb;
        pv[1] = pv[0]; ps[1] = ps[0]; pc[1] = pc[0];
        pts[1] = pts[0]; ptc[1] = ptc[0];
        pv[0] = v;
        ps[0] = clampw(rs);
        pc[0] = clampw(rc);
        if (tag != "") begin
            pts[0] = tag; ptc[0] = tag;
        end else begin
            pts[0] = clipped(rs) ? "R6" : (q < 0 ? "R4" : "R2");
            ptc[0] = clipped(rc) ? "R6" : (q < 0 ? "R4" : "R3");
        end
        in_valid = v;
        q_in  = QW'(q);
        sh_in = (FRAC+2)'(sh);
        ch_in = (FRAC+1)'(ch);
    endtask

    initial begin
        int n;
        for (int i = 0; i < 2; i++) begin
            pv[i] = 1'b0; ps[i] = 0; pc[i] = 0; pts[i] = "R7"; ptc[i] = "R7";
        end
        rst = 1'b1;
        repeat (4) @(posedge clk);
        // R7: reset state seen at the ports
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || sinh_out !== '0 || cosh_out !== '0) begin
            fails++;
            $display("FAIL R7 reset: actual v=%0b s=%0d c=%0d expected 0 0 0",
                     out_valid, sinh_out, cosh_out);
        end
        rst = 1'b0;

        // R9: formats, q=1, ch=1.0, sh=0 -> 0.75 / 1.25
        step(1'b1, 1, 0, 256, "R9");
        // R5: per-term floor, q=0 sh=+1 ch=0 -> sinh +1, cosh -1
        step(1'b1, 0, 1, 0, "R5");
        step(1'b1, 0, -1, 0, "R5");
        step(1'b1, -3, 5, 3, "R5");
        step(1'b0, 0, 0, 0, "");
        step(1'b0, 5, 100, 100, "");  // R8: ignored while invalid

        // near-exhaustive sweep over q with a grid of input pairs
        n = 0;
        for (int q = -(1 << (QW-1)); q < (1 << (QW-1)); q++) begin
            for (int sh = -512; sh < 512; sh += 37) begin
                for (int ch = 0; ch < 512; ch += 41) begin
                    step(1'b1, q, sh, ch, "");
                    n++;
                    if (n % 7 == 3) step(1'b0, q, ch, sh, "");
                end
            end
            // extreme corners for R6
            step(1'b1, q, -512, 511, "");
            step(1'b1, q, 511, 511, "");
        end

        // drain and confirm hold (R8)
        repeat (4) step(1'b0, 0, 0, 0, "");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: done=0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule